// File: doc/BRIEF.md
# Host-to-Coprocessor Mailbox

This block is the register exchange between a narrow host bus and a 32-bit embedded coprocessor bus. The host has a byte-wide window decoded from the low 16 bits of its address. The coprocessor has a word-addressed window in its own 32-bit address space. Through these two windows the two sides pass a command byte one way, and a reply byte and a completion code the other way.

When the host writes the command port, the byte is latched and a pending flag is raised. The coprocessor polls that flag in its status word. It then reads the command byte, and that read retires the flag. The coprocessor answers by writing a reply word, whose low byte the host can read. Writing a control word with its acknowledge bit set posts a fixed completion code that the host polls. Reads on both sides are combinational from the held state and return zero when the read strobe is low. Every update takes effect at the next rising clock edge.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, every host read returns 0x00 and every coprocessor read returns 0x00000000. This holds for the command byte, the pending flag, the reply byte and the completion code.
- R2: A host write to offset 0x3802 latches the data byte. From the next cycle, a coprocessor read of 0x40000010 returns that byte in bits 7:0, with bits 31:8 zero.
- R3: A host write to offset 0x3802 sets the pending flag. A coprocessor read of 0x40000020 returns the flag in bit 3, with every other bit zero.
- R4: A coprocessor read of 0x40000010 clears the pending flag from the next cycle, provided no host command write happens in the same cycle.
- R5: When a host command write and a coprocessor read of 0x40000010 fall in the same cycle, the host write wins. The flag stays set and the new byte is latched. The read in that cycle returns the previous byte.
- R6: A host read of offset 0x3800 returns bits 7:0 of the last word the coprocessor wrote to 0x40000000.
- R7: A coprocessor write to 0x4000002C with data bit 1 set makes the host read of offset 0x3804 return 0x80 from the next cycle on. A write there with bit 1 clear changes nothing.
- R8: Host address bits above bit 15 play no part in the decode.
- R9: Host reads of offset 0x3802 and of any unmapped offset return 0x00, and coprocessor reads of any other address return zero. Writes to unmapped addresses on either side leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | HOST_AW | Host address; only bits 15:0 are decoded |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, zero when h_rd is low |
| c_addr | input | 32 | Coprocessor address |
| c_rd | input | 1 | Coprocessor read strobe |
| c_wr | input | 1 | Coprocessor write strobe |
| c_wdata | input | 32 | Coprocessor write data |
| c_rdata | output | 32 | Coprocessor read data, zero when c_rd is low |

## Verification
A wrong pending flag shows at the very next coprocessor status read as a bit 3 that disagrees with the host's write history. A wrong pending flag most often comes from a lost priority on a same-cycle collision. A corrupted command, reply or completion register shows one cycle after the offending write, on the first read of that location. If unmapped traffic leaked into state, the damage would stay hidden until the affected register is read. For that reason the random stream reads every mapped location often, mixed with the unmapped writes.

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int HOST_AW = 24,
  parameter logic [7:0] ACK_CODE = 8'h80,
  parameter int FLAG_BIT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic               h_rd,
  input  logic               h_wr,
  input  logic [7:0]         h_wdata,
  output logic [7:0]         h_rdata,
  input  logic [31:0]        c_addr,
  input  logic               c_rd,
  input  logic               c_wr,
  input  logic [31:0]        c_wdata,
  output logic [31:0]        c_rdata
);
  localparam logic [15:0] H_REPLY = 16'h3800;
  localparam logic [15:0] H_CMD   = 16'h3802;
  localparam logic [15:0] H_CODE  = 16'h3804;
  localparam logic [31:0] C_REPLY = 32'h4000_0000;
  localparam logic [31:0] C_CMD   = 32'h4000_0010;
  localparam logic [31:0] C_STAT  = 32'h4000_0020;
  localparam logic [31:0] C_CTRL  = 32'h4000_002C;
  localparam int ACK_BIT = 1;

  logic [15:0] h_off;
  logic        cmd_wr, cmd_take, reply_wr, ack_wr;
  logic [7:0]  cmd_q, reply_q, code_q;
  logic        pend_q;

  assign h_off    = h_addr[15:0];
  assign cmd_wr   = h_wr && (h_off == H_CMD);
  assign cmd_take = c_rd && (c_addr == C_CMD);
  assign reply_wr = c_wr && (c_addr == C_REPLY);
  assign ack_wr   = c_wr && (c_addr == C_CTRL) && c_wdata[ACK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      reply_q <= '0;
      code_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= h_wdata;
      if (cmd_wr) pend_q <= 1'b1;
      else if (cmd_take) pend_q <= 1'b0;
      if (reply_wr) reply_q <= c_wdata[7:0];
      if (ack_wr) code_q <= ACK_CODE;
    end
  end

  always_comb begin
    h_rdata = '0;
    if (h_rd) begin
      unique case (h_off)
        H_REPLY: h_rdata = reply_q;
        H_CODE:  h_rdata = code_q;
        default: h_rdata = '0;
      endcase
    end
  end

  always_comb begin
    c_rdata = '0;
    if (c_rd) begin
      unique case (c_addr)
        C_CMD:   c_rdata = {24'h0, cmd_q};
        C_STAT:  c_rdata[FLAG_BIT] = pend_q;
        default: c_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
  parameter int HOST_AW = 24,
  parameter logic [7:0] ACK_CODE = 8'h80
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HOST_AW-1:0] h_addr,
  input logic               h_wr,
  input logic [7:0]         h_wdata,
  input logic [31:0]        c_addr,
  input logic               c_rd,
  input logic               c_wr,
  input logic [31:0]        c_wdata,
  input logic [31:0]        c_rdata,
  input logic               pend_q,
  input logic [7:0]         cmd_q,
  input logic [7:0]         code_q
);
  logic hw_cmd;
  assign hw_cmd = h_wr && (h_addr[15:0] == 16'h3802);

  AST_CMD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hw_cmd |=> pend_q && (cmd_q == $past(h_wdata))); // R2
  AST_STAT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_addr == 32'h4000_0020) |-> (c_rdata[31:4] == '0 && c_rdata[2:0] == '0)); // R3
  AST_PEND_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_addr == 32'h4000_0010 && !hw_cmd) |=> !pend_q); // R4
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_cmd |=> $stable(cmd_q)); // R9
  AST_CODE_POST: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && c_addr == 32'h4000_002C && c_wdata[1]) |=> (code_q == ACK_CODE)); // R7
  AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == ACK_CODE) |=> (code_q == ACK_CODE)); // R7
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.HOST_AW(HOST_AW), .ACK_CODE(ACK_CODE)) chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
  .c_addr(c_addr), .c_rd(c_rd), .c_wr(c_wr), .c_wdata(c_wdata), .c_rdata(c_rdata),
  .pend_q(pend_q), .cmd_q(cmd_q), .code_q(code_q));

// File: tb/cmd_mailbox_test.sv
`timescale 1ns/1ps
module cmd_mailbox_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [23:0] h_addr = '0;
  logic h_rd = 0, h_wr = 0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic [31:0] c_addr = '0, c_wdata = '0, c_rdata;
  logic c_rd = 0, c_wr = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_cmd, m_reply, m_code;
  logic m_pend;

  always #10 clk = ~clk;

  cmd_mailbox uut (.clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .c_addr(c_addr), .c_rd(c_rd), .c_wr(c_wr),
    .c_wdata(c_wdata), .c_rdata(c_rdata));

  function automatic logic [7:0] host_exp();
    if (!h_rd) return 8'h00;
    if (h_addr[15:0] == 16'h3800) return m_reply;
    if (h_addr[15:0] == 16'h3804) return m_code;
    return 8'h00;
  endfunction

  function automatic logic [31:0] cop_exp();
    if (!c_rd) return 32'h0;
    if (c_addr == 32'h4000_0010) return {24'h0, m_cmd};
    if (c_addr == 32'h4000_0020) return {28'h0, m_pend, 3'b000};
    return 32'h0;
  endfunction

  task automatic model_step();
    if (h_wr && h_addr[15:0] == 16'h3802) begin m_cmd = h_wdata; m_pend = 1'b1; end
    else if (c_rd && c_addr == 32'h4000_0010) m_pend = 1'b0;
    if (c_wr && c_addr == 32'h4000_0000) m_reply = c_wdata[7:0];
    if (c_wr && c_addr == 32'h4000_002C && c_wdata[1]) m_code = 8'h80;
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle();
    h_rd = 0; h_wr = 0; c_rd = 0; c_wr = 0;
  endtask

  task automatic cycle(string htag, string ctag);
    #5;
    chk(htag, {24'h0, h_rdata}, {24'h0, host_exp()});
    chk(ctag, c_rdata, cop_exp());
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
  endtask

  function automatic string htag_of();
    case (h_addr[15:0]) 16'h3800: return "R6"; 16'h3804: return "R7"; default: return "R9"; endcase
  endfunction
  function automatic string ctag_of();
    case (c_addr) 32'h4000_0010: return "R2"; 32'h4000_0020: return "R3"; default: return "R9"; endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] hl [5] = '{16'h3800, 16'h3802, 16'h3804, 16'h3801, 16'h1234};
    logic [31:0] cl [7] = '{32'h4000_0000, 32'h4000_0010, 32'h4000_0020, 32'h4000_002C,
                            32'h4000_0024, 32'h4000_0011, 32'h0000_0020};
    void'($urandom(32'd4242));
    m_cmd = 0; m_reply = 0; m_code = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, all readable locations
    h_rd = 1; h_addr = 24'h003800; c_rd = 1; c_addr = 32'h4000_0010; cycle("R1", "R1");
    h_rd = 1; h_addr = 24'h003804; c_rd = 1; c_addr = 32'h4000_0020; cycle("R1", "R1");
    // R2 R3: command write then poll and fetch
    h_wr = 1; h_addr = 24'h003802; h_wdata = 8'hA5; cycle("R2", "R2");
    c_rd = 1; c_addr = 32'h4000_0020; cycle("R9", "R3");
    c_rd = 1; c_addr = 32'h4000_0010; cycle("R9", "R2");
    // R4: flag retired by fetch
    c_rd = 1; c_addr = 32'h4000_0020; cycle("R9", "R4");
    // R5: collision, host write wins, old byte read
    h_wr = 1; h_addr = 24'h003802; h_wdata = 8'h11; cycle("R5", "R5");
    h_wr = 1; h_addr = 24'h003802; h_wdata = 8'h22; c_rd = 1; c_addr = 32'h4000_0010; cycle("R5", "R5");
    c_rd = 1; c_addr = 32'h4000_0020; cycle("R5", "R5");
    // R8: upper host bits ignored
    h_wr = 1; h_addr = 24'hFF3802; h_wdata = 8'h5C; cycle("R8", "R8");
    c_rd = 1; c_addr = 32'h4000_0010; cycle("R8", "R8");
    c_wr = 1; c_addr = 32'h4000_0000; c_wdata = 32'hDEAD_BE3C; cycle("R6", "R6");
    h_rd = 1; h_addr = 24'h7F3800; cycle("R8", "R8");
    // R7: bit1 clear has no effect, then set
    c_wr = 1; c_addr = 32'h4000_002C; c_wdata = 32'hFFFF_FFFD; cycle("R7", "R7");
    h_rd = 1; h_addr = 24'h003804; cycle("R7", "R7");
    c_wr = 1; c_addr = 32'h4000_002C; c_wdata = 32'h0000_0002; cycle("R7", "R7");
    h_rd = 1; h_addr = 24'h003804; cycle("R7", "R7");
    // R9: command port reads zero, unmapped write harmless
    h_rd = 1; h_addr = 24'h003802; cycle("R9", "R9");
    c_wr = 1; c_addr = 32'h4000_0001; c_wdata = 32'hFFFF_FFFF; cycle("R9", "R9");
    h_rd = 1; h_addr = 24'h003800; cycle("R9", "R9");
    // random stream
    for (int i = 0; i < 3000; i++) begin
      h_rd = 1'($urandom); h_wr = ($urandom % 4) == 0; c_rd = 1'($urandom); c_wr = ($urandom % 4) == 0;
      h_addr = {8'($urandom), hl[$urandom % 5]};
      c_addr = cl[$urandom % 7];
      h_wdata = 8'($urandom); c_wdata = $urandom;
      cycle(htag_of(), ctag_of());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule